// File: doc/BRIEF.md
# Complementary Output Short Guard

This block watches three complementary PWM output pairs. A pair counts as shorted when both of its outputs sit at the active level in the same cycle. The active level is set by a polarity input. When any pair is shorted, the block sets a sticky short flag in a 16-bit control/status register. Depending on two enable bits in that register, the flag can raise an interrupt request and can force all six monitored pins to high impedance.

Software reaches the register over a simple bus with a read strobe, a write strobe and write data. Read data always shows the current register contents.

Two rules protect the state:
- Software can clear the flag only with a write of 0 to the flag bit, and only after a read that returned the flag as 1.
- The high-impedance enable is loaded by the first register write after reset and cannot be changed after that.

Top module: `pwm_short_guard`

## Requirements
- R1: After reset the register reads 0x0000, `irq` is 0 and all bits of `hiz_en` are 0.
- R2: Pair k is made of `pin_level[2k]` and `pin_level[2k+1]`. A pair is shorted when both of its bits equal `act_level` (1 = active high, 0 = active low). The clock edge that samples any shorted pair sets the flag, which is bit 15 of the register.
- R3: The flag clears only on a write with bit 15 = 0, and only after a read strobe that saw the flag at 1. A write of 0 without such a read leaves the flag at 1. A write of 1 to bit 15 has no effect.
- R4: If a short is present on the same edge as a qualified clearing write, the flag stays 1.
- R5: Bit 9 is the high-impedance enable. While bit 9 and the flag are both 1, all six bits of `hiz_en` are 1. While bit 9 is 0, `hiz_en` stays 0 even with the flag set.
- R6: The first register write after reset loads bit 9. Every later write leaves bit 9 unchanged.
- R7: Bit 8 is the interrupt enable and can be written any number of times. `irq` is 1 exactly when bit 8 and the flag are both 1.
- R8: Bits 14 to 10 and bits 7 to 0 always read 0, whatever is written to them.
- R9: Once the pins are forced to high impedance, they stay forced after the short goes away, until the flag is cleared.
- R10: A qualified clearing write uses up the read. After it, clearing the flag again needs a new read that sees the flag at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Current register contents |
| pin_level | input | 6 | Raw levels of the six monitored outputs, one pair per two bits |
| act_level | input | 1 | Active level of the monitored outputs |
| hiz_en | output | 6 | Per-pin high-impedance force |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is a clearing write that is already armed by an earlier read but meets a short that is still present on the same edge. In that case the flag must stay set while the read is still used up. The stimulus sets the flag, reads it, and then keeps the shorted pair driven through the write. It then removes the short and tries to clear again without a new read. That second attempt must fail, which shows that the earlier read was consumed even though the flag stayed set. A separate reset at the end gives the one-time enable a fresh first write with a different value, so both settings of the high-impedance enable are exercised.

// File: rtl/psg_pkg.sv
package psg_pkg;
  localparam int REG_W    = 16;
  localparam int FLAG_POS = 15;
  localparam int HIZ_POS  = 9;
  localparam int IE_POS   = 8;
  localparam logic [REG_W-1:0] LIVE_MASK =
    (REG_W'(1) << FLAG_POS) | (REG_W'(1) << HIZ_POS) | (REG_W'(1) << IE_POS);

  // A pair is shorted when both legs sit at the active level.
  function automatic logic pair_hits(input logic leg_a, input logic leg_b,
                                     input logic act);
    return (leg_a == act) && (leg_b == act);
  endfunction

  // Assemble the register image; reserved positions are zero.
  function automatic logic [REG_W-1:0] pack_status(input logic flag,
                                                   input logic hiz,
                                                   input logic ie);
    logic [REG_W-1:0] img;
    img = '0;
    img[FLAG_POS] = flag;
    img[HIZ_POS]  = hiz;
    img[IE_POS]   = ie;
    return img;
  endfunction
endpackage

// File: rtl/psg_short_detect.sv
module psg_short_detect #(
  parameter int NUM_PAIRS = 3,
  localparam int PIN_W = 2 * NUM_PAIRS
) (
  input  logic [PIN_W-1:0] pin_level,
  input  logic             act_level,
  output logic             short_any
);
  import psg_pkg::*;

  logic [NUM_PAIRS-1:0] pair_short;

  for (genvar k = 0; k < NUM_PAIRS; k++) begin : g_pair
    assign pair_short[k] = pair_hits(pin_level[2*k], pin_level[2*k+1], act_level);
  end

  assign short_any = |pair_short;
endmodule

// File: rtl/psg_status_ctrl.sv
module psg_status_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic short_any,
  input  logic rd_evt,
  input  logic wr_evt,
  input  logic wr_flag_bit,
  output logic flag,
  output logic armed,
  output logic clear_evt
);
  logic clr_ok;
  logic flag_d, armed_d;

  assign clr_ok    = wr_evt && !wr_flag_bit && armed;
  assign clear_evt = clr_ok && !short_any;

  always_comb begin
    flag_d = flag;
    if (short_any)   flag_d = 1'b1;
    else if (clr_ok) flag_d = 1'b0;
    armed_d = armed;
    if (clr_ok)                armed_d = 1'b0;
    else if (rd_evt && flag)   armed_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag  <= 1'b0;
      armed <= 1'b0;
    end else begin
      flag  <= flag_d;
      armed <= armed_d;
    end
  end

  p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    short_any |=> flag);
  p_clear_needs_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag) |-> ($past(armed) && $past(wr_evt) && !$past(wr_flag_bit)));
  p_armed_implies_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> flag);
endmodule

// File: rtl/psg_cfg_reg.sv
module psg_cfg_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_evt,
  input  logic wr_hiz_bit,
  input  logic wr_ie_bit,
  output logic hiz_cfg,
  output logic ie_cfg
);
  logic locked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hiz_cfg <= 1'b0;
      ie_cfg  <= 1'b0;
      locked  <= 1'b0;
    end else if (wr_evt) begin
      ie_cfg <= wr_ie_bit;
      locked <= 1'b1;
      if (!locked) hiz_cfg <= wr_hiz_bit;
    end
  end

  p_hiz_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(locked) |-> $stable(hiz_cfg));
  p_ie_follows_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_evt) |-> (ie_cfg == $past(wr_ie_bit)));
endmodule

// File: rtl/pwm_short_guard.sv
module pwm_short_guard #(
  parameter int NUM_PAIRS = 3,
  localparam int PIN_W = 2 * NUM_PAIRS,
  localparam int REG_W = psg_pkg::REG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_rd,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic [PIN_W-1:0] pin_level,
  input  logic             act_level,
  output logic [PIN_W-1:0] hiz_en,
  output logic             irq
);
  import psg_pkg::*;

  logic short_any;
  logic flag, armed, clear_evt;
  logic hiz_cfg, ie_cfg;
  logic force_hiz;
  logic unused_wdata;

  assign unused_wdata = ^(reg_wdata & ~LIVE_MASK);

  psg_short_detect #(.NUM_PAIRS(NUM_PAIRS)) u_detect (
    .pin_level (pin_level),
    .act_level (act_level),
    .short_any (short_any)
  );

  psg_status_ctrl u_status (
    .clk         (clk),
    .rst_n       (rst_n),
    .short_any   (short_any),
    .rd_evt      (reg_rd),
    .wr_evt      (reg_wr),
    .wr_flag_bit (reg_wdata[FLAG_POS]),
    .flag        (flag),
    .armed       (armed),
    .clear_evt   (clear_evt)
  );

  psg_cfg_reg u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_evt     (reg_wr),
    .wr_hiz_bit (reg_wdata[HIZ_POS]),
    .wr_ie_bit  (reg_wdata[IE_POS]),
    .hiz_cfg    (hiz_cfg),
    .ie_cfg     (ie_cfg)
  );

  assign force_hiz = flag && hiz_cfg;
  assign hiz_en    = {PIN_W{force_hiz}};
  assign irq       = flag && ie_cfg;
  assign reg_rdata = pack_status(flag, hiz_cfg, ie_cfg);

  p_reserved_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata & ~LIVE_MASK) == '0);
  p_irq_matches_reg_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (reg_rdata[FLAG_POS] && reg_rdata[IE_POS]));
  p_hiz_uniform_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hiz_en == '0) || (hiz_en == '1));
  p_hiz_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((hiz_en != '0) && !clear_evt) |=> (hiz_en == '1));
  p_short_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    short_any |=> reg_rdata[FLAG_POS]);
endmodule

// File: tb/pwm_short_guard_tb.sv
module pwm_short_guard_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_rd = 1'b0;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [5:0]  pin_level = '0;
  logic        act_level = 1'b1;
  logic [5:0]  hiz_en;
  logic        irq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  pwm_short_guard dut_i (
    .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_level(pin_level),
    .act_level(act_level), .hiz_en(hiz_en), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cycles++;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%04h expected=0x%04h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    reg_rd = 1'b0; reg_wr = 1'b0; pin_level = '0; act_level = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic do_write(input logic [15:0] d);
    reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic do_read(output logic [15:0] d);
    reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic make_short(input logic [5:0] pins, input logic act);
    pin_level = pins; act_level = act;
    @(negedge clk);
    pin_level = (act) ? 6'b000000 : 6'b111111;
  endtask

  task automatic t_reset_state();
    check("R1 rdata", reg_rdata, 16'h0000);
    check("R1 irq", {15'd0, irq}, 16'd0);
    check("R1 hiz", {10'd0, hiz_en}, 16'd0);
  endtask

  task automatic t_first_write();
    logic [15:0] d;
    do_write(16'h7FFF);
    do_read(d);
    check("R8 reserved/R6 load", d, 16'h0300);
    do_write(16'h0000);
    check("R6 locked/R7 ie clear", reg_rdata, 16'h0200);
    do_write(16'h0100);
    check("R7 ie set", reg_rdata, 16'h0300);
  endtask

  task automatic t_no_short_pattern();
    pin_level = 6'b010101; act_level = 1'b1;
    @(negedge clk);
    check("R2 no pair shorted", reg_rdata, 16'h0300);
    pin_level = 6'b101010; act_level = 1'b0;
    @(negedge clk);
    check("R2 no pair shorted low", reg_rdata, 16'h0300);
    pin_level = '0; act_level = 1'b1;
  endtask

  task automatic t_short_and_hold();
    make_short(6'b001100, 1'b1);
    check("R2 flag set", reg_rdata, 16'h8300);
    check("R7 irq", {15'd0, irq}, 16'd1);
    check("R5 hiz forced", {10'd0, hiz_en}, 16'h003F);
    @(negedge clk);
    check("R9 hiz held", {10'd0, hiz_en}, 16'h003F);
  endtask

  task automatic t_clear_rules();
    logic [15:0] d;
    do_write(16'h0300);
    check("R3 no read no clear", reg_rdata, 16'h8300);
    do_write(16'h8300);
    check("R3 write one", reg_rdata, 16'h8300);
    do_read(d);
    check("R3 read sees flag", d, 16'h8300);
    do_write(16'h8300);
    check("R3 write one after read", reg_rdata, 16'h8300);
    do_write(16'h0300);
    check("R3 cleared", reg_rdata, 16'h0300);
    check("R3 irq low", {15'd0, irq}, 16'd0);
    check("R9 hiz released", {10'd0, hiz_en}, 16'd0);
  endtask

  task automatic t_active_low_rearm();
    logic [15:0] d;
    make_short(6'b111100, 1'b0);
    check("R2 active low", reg_rdata, 16'h8300);
    do_write(16'h0300);
    check("R10 no new read", reg_rdata, 16'h8300);
    do_read(d);
    do_write(16'h0300);
    check("R10 cleared after read", reg_rdata, 16'h0300);
  endtask

  task automatic t_set_wins();
    logic [15:0] d;
    make_short(6'b110000, 1'b1);
    do_read(d);
    pin_level = 6'b110000;
    do_write(16'h0300);
    pin_level = 6'b000000;
    check("R4 set wins", reg_rdata, 16'h8300);
    do_write(16'h0300);
    check("R10 read consumed", reg_rdata, 16'h8300);
    do_read(d);
    do_write(16'h0300);
    check("R4 final clear", reg_rdata, 16'h0300);
  endtask

  task automatic t_hiz_disabled();
    do_reset();
    check("R1 second reset", reg_rdata, 16'h0000);
    do_write(16'h0100);
    do_write(16'h0200);
    check("R6 later write ignored", reg_rdata, 16'h0000);
    do_write(16'h0100);
    make_short(6'b000011, 1'b1);
    check("R5 flag no hiz", reg_rdata, 16'h8100);
    check("R5 hiz off", {10'd0, hiz_en}, 16'd0);
    check("R7 irq on", {15'd0, irq}, 16'd1);
    do_write(16'h0000);
    check("R7 ie off irq low", {15'd0, irq}, 16'd0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_first_write();
        t_no_short_pattern();
        t_short_and_hold();
        t_clear_rules();
        t_active_low_rearm();
        t_set_wins();
        t_hiz_disabled();
      end
      begin
        wait (cycles >= WATCHDOG);
        checks++; errors++;
        $display("FAIL watchdog actual=%0d expected<%0d", cycles, WATCHDOG);
      end
    join_any
    disable fork;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule